// File: doc/BRIEF.md
# Lane Predication Enable Stack

This block keeps the per-lane predication state of a lane array that executes one broadcast instruction stream. Each lane holds a fixed-depth stack of condition bits. The conditional control instructions (if, else, endif) push, invert or pop that stack using the lane's own comparison result. A lane is enabled when every bit it currently holds is one. The block turns that enable into a per-lane write gate for data instructions. A forced load or store opens the gate on every lane.

All lanes update their stacks on the clock edge at which the broadcast instruction is presented. The write gate for a data instruction is combinational from the enable state that earlier instructions left behind. Running out of stack is not repaired here. Each lane reports an attempted push onto a full stack, or a pop from an empty stack, through a sticky flag.

Top module: `pred_stack_top`

## Requirements
- R1: A lane's enable output is the AND of all bits currently held in its stack. An empty stack gives an enabled lane.
- R2: Opcode 1 (if) pushes the lane's `cond_i` bit onto its stack: 1 when the condition holds, 0 otherwise.
- R3: Opcode 3 (endif) pops the top bit, which restores the enable the lane had before the matching if.
- R4: Opcode 2 (else) inverts the top bit only in lanes whose lower stack bits are all one, so a lane disabled by an outer level stays disabled. On an empty stack, else has no effect.
- R5: Control opcodes update the stacks of every lane, disabled or not, on the clock edge of the instruction. The new enable is visible from the next cycle.
- R6: For opcode 4 (data write), `wr_gate_o` equals the lane enables when `forced_i` is 0 and is all ones when `forced_i` is 1. For any other opcode, `wr_gate_o` is zero.
- R7: The stack holds 8 entries per lane. A push onto a full stack leaves the stack unchanged and sets that lane's sticky overflow flag.
- R8: A pop from an empty stack leaves the stack empty and sets that lane's sticky underflow flag.
- R9: Synchronous active-high reset empties every stack and clears both flags.
- R10: Opcode 0 and opcodes 5 to 7 leave all stacks and flags unchanged and give a zero write gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Broadcast opcode class |
| cond_i | input | 16 | Per-lane comparison result |
| forced_i | input | 1 | Forced access flag for data opcodes |
| lane_en_o | output | 16 | Per-lane enable state |
| wr_gate_o | output | 16 | Per-lane write gate for the current instruction |
| ovf_o | output | 16 | Sticky per-lane overflow flag |
| unf_o | output | 16 | Sticky per-lane underflow flag |

## Verification
The hardest case to reach from the ports is the else rule inside a nest. It needs lanes whose outer bit is zero and whose inner bit is one, next to lanes where both are one. Without that mix, a design that inverts the top bit unconditionally gives the same outputs. The stimulus table first pushes two overlapping masks so that all four outer/inner combinations appear across the lanes, then applies else. The full and empty boundaries are reached with exactly eight pushes and then one more, followed by the same count of pops.

// File: rtl/pred_pkg.sv
package pred_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_IF    = 3'd1,
        OP_ELSE  = 3'd2,
        OP_ENDIF = 3'd3,
        OP_DATA  = 3'd4
    } op_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic flip;
        logic data;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [2:0] op);
        ctl_t c;
        c = '0;
        case (op)
            OP_IF:    c.push = 1'b1;
            OP_ELSE:  c.flip = 1'b1;
            OP_ENDIF: c.pop  = 1'b1;
            OP_DATA:  c.data = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pred_decode.sv
module pred_decode
    import pred_pkg::*;
(
    input  logic [2:0] op_i,
    output ctl_t       ctl_o
);
    always_comb ctl_o = decode_op(op_i);
endmodule

// File: rtl/pred_gate.sv
module pred_gate #(
    parameter int LANES = 16
) (
    input  logic             data_i,
    input  logic             forced_i,
    input  logic [LANES-1:0] en_i,
    output logic [LANES-1:0] gate_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign gate_o[g] = data_i & (forced_i | en_i[g]);
    end
endmodule

// File: rtl/pred_lane.sv
module pred_lane
    import pred_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_i,
    input  logic cond_i,
    output logic en_o,
    output logic ovf_o,
    output logic unf_o
);
    logic [DEPTH-1:0] bits_q, bits_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             ovf_q, ovf_d, unf_q, unf_d;
    logic             full, empty, lower_ok;

    // Mask of the n lowest stack positions.
    function automatic logic [DEPTH-1:0] held_mask(input logic [CW-1:0] n);
        logic [DEPTH-1:0] m;
        m = '0;
        for (int i = 0; i < DEPTH; i++)
            if (CW'(i) < n) m[i] = 1'b1;
        return m;
    endfunction

    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign en_o     = &(bits_q | ~held_mask(cnt_q));
    assign lower_ok = &(bits_q | ~held_mask(cnt_q - CW'(1)));

    always_comb begin
        bits_d = bits_q;
        cnt_d  = cnt_q;
        ovf_d  = ovf_q;
        unf_d  = unf_q;
        if (ctl_i.push) begin
            if (full) begin
                ovf_d = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++)
                    if (CW'(i) == cnt_q) bits_d[i] = cond_i;
                cnt_d = cnt_q + CW'(1);
            end
        end else if (ctl_i.pop) begin
            if (empty) unf_d = 1'b1;
            else       cnt_d = cnt_q - CW'(1);
        end else if (ctl_i.flip && !empty && lower_ok) begin
            for (int i = 0; i < DEPTH; i++)
                if (CW'(i) == cnt_q - CW'(1)) bits_d[i] = ~bits_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            bits_q <= bits_d;
            cnt_q  <= cnt_d;
            ovf_q  <= ovf_d;
            unf_q  <= unf_d;
        end
    end

    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

    a_r2_push_grows: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.push && !full) |=> (cnt_q == $past(cnt_q) + CW'(1)));
    a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.pop && !empty) |=> (cnt_q == $past(cnt_q) - CW'(1)));
    a_r4_outer_off_kept: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.flip && !lower_ok) |=> $stable(bits_q));
    a_r7_full_push_holds: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.push && full) |=> ($stable(bits_q) && $stable(cnt_q) && ovf_q));
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    a_r8_empty_pop_stays: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.pop && empty) |=> (cnt_q == '0 && unf_q));
    a_r8_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        unf_q |=> unf_q);
    a_r1_empty_enabled: assert property (@(posedge clk) disable iff (rst)
        empty |-> en_o);
endmodule

// File: rtl/pred_stack_top.sv
module pred_stack_top
    import pred_pkg::*;
#(
    parameter int LANES = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_i,
    input  logic [LANES-1:0] cond_i,
    input  logic             forced_i,
    output logic [LANES-1:0] lane_en_o,
    output logic [LANES-1:0] wr_gate_o,
    output logic [LANES-1:0] ovf_o,
    output logic [LANES-1:0] unf_o
);
    ctl_t ctl;

    pred_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pred_lane #(.DEPTH(DEPTH)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .ctl_i  (ctl),
            .cond_i (cond_i[g]),
            .en_o   (lane_en_o[g]),
            .ovf_o  (ovf_o[g]),
            .unf_o  (unf_o[g])
        );
    end

    pred_gate #(.LANES(LANES)) u_gate (
        .data_i   (ctl.data),
        .forced_i (forced_i),
        .en_i     (lane_en_o),
        .gate_o   (wr_gate_o)
    );

    a_r6_gate_idle: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_DATA) |-> (wr_gate_o == '0));
    a_r6_forced_open: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_DATA && forced_i) |-> (&wr_gate_o));
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_NOP || op_i > OP_DATA) |=> ($stable(lane_en_o) && $stable(ovf_o) && $stable(unf_o)));
endmodule

// File: tb/pred_stack_top_bench.sv
module pred_stack_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 12;

    // {op[3], forced[1], cond[16], exp_gate[16], exp_en_after[16]}
    localparam logic [51:0] TBL [0:N_VEC-1] = '{
        {3'd1, 1'b0, 16'hFF00, 16'h0000, 16'hFF00},
        {3'd1, 1'b0, 16'hF0F0, 16'h0000, 16'hF000},
        {3'd4, 1'b0, 16'h0000, 16'hF000, 16'hF000},
        {3'd2, 1'b0, 16'h0000, 16'h0000, 16'h0F00},
        {3'd4, 1'b1, 16'h0000, 16'hFFFF, 16'h0F00},
        {3'd4, 1'b0, 16'h1234, 16'h0F00, 16'h0F00},
        {3'd3, 1'b0, 16'h0000, 16'h0000, 16'hFF00},
        {3'd2, 1'b0, 16'h0000, 16'h0000, 16'h00FF},
        {3'd3, 1'b0, 16'h0000, 16'h0000, 16'hFFFF},
        {3'd1, 1'b0, 16'hAAAA, 16'h0000, 16'hAAAA},
        {3'd3, 1'b0, 16'h0000, 16'h0000, 16'hFFFF},
        {3'd0, 1'b0, 16'hFFFF, 16'h0000, 16'hFFFF}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op;
    logic [15:0] cond;
    logic        forced;
    logic [15:0] lane_en, wr_gate, ovf, unf;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_stack_top u_pred_stack_top (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op),
        .cond_i    (cond),
        .forced_i  (forced),
        .lane_en_o (lane_en),
        .wr_gate_o (wr_gate),
        .ovf_o     (ovf),
        .unf_o     (unf)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, look at the gate just before the rising edge,
    // then settle one unit after the rising edge for the registered state.
    task automatic step(input logic [2:0] o, input logic [15:0] c, input logic f,
                        output logic [15:0] gate_seen);
        @(negedge clk);
        op = o; cond = c; forced = f;
        #(CLK_PERIOD/2 - 1);
        gate_seen = wr_gate;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op = 3'd0; cond = '0; forced = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] g;
        rst = 1'b1; op = '0; cond = '0; forced = 1'b0;
        do_reset();
        // R9: reset state
        check("R9 reset enable", lane_en, 16'hFFFF);
        check("R9 reset ovf", ovf, 16'h0000);
        check("R9 reset unf", unf, 16'h0000);

        // Table: R1 R2 R3 R4 R5 R6
        for (int k = 0; k < N_VEC; k++) begin
            step(TBL[k][51:49], TBL[k][47:32], TBL[k][48], g);
            check($sformatf("R6 gate vec %0d", k), g, TBL[k][31:16]);
            check($sformatf("R1/R5 enable vec %0d", k), lane_en, TBL[k][15:0]);
        end

        // R7: fill to depth, then one more push
        for (int k = 0; k < 8; k++) step(3'd1, 16'hFFFF, 1'b0, g);
        check("R7 no ovf at depth", ovf, 16'h0000);
        step(3'd1, 16'h0000, 1'b0, g);
        check("R7 ovf set", ovf, 16'hFFFF);
        check("R7 full push dropped", lane_en, 16'hFFFF);

        // R8: empty the stack, then one more pop
        for (int k = 0; k < 8; k++) step(3'd3, 16'h0000, 1'b0, g);
        check("R8 no unf at empty", unf, 16'h0000);
        step(3'd3, 16'h0000, 1'b0, g);
        check("R8 unf set", unf, 16'hFFFF);
        check("R8 stays empty", lane_en, 16'hFFFF);
        check("R7 ovf sticky", ovf, 16'hFFFF);

        // R4: else on an empty stack
        step(3'd2, 16'h0000, 1'b0, g);
        check("R4 else empty", lane_en, 16'hFFFF);
        step(3'd1, 16'h00FF, 1'b0, g);
        check("R2 push after unf", lane_en, 16'h00FF);

        // R10: unused opcode
        step(3'd7, 16'hFF00, 1'b1, g);
        check("R10 gate zero", g, 16'h0000);
        check("R10 enable kept", lane_en, 16'h00FF);
        step(3'd5, 16'h0000, 1'b0, g);
        check("R10 enable kept op5", lane_en, 16'h00FF);
        check("R8 unf sticky", unf, 16'hFFFF);

        // R9: reset clears flags and stacks
        do_reset();
        check("R9 enable after reset", lane_en, 16'hFFFF);
        check("R9 ovf after reset", ovf, 16'h0000);
        check("R9 unf after reset", unf, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule